// File: doc/BRIEF.md
# Lock-Masked Tree Pseudo-LRU Victim Selector

This block holds the replacement state of an 8-way set-associative cache: one 7-bit binary decision tree per set, plus an instruction lock and a data lock for every way of every set. Hits move the tree away from the way that was touched. Invalidations move the tree toward the way that was dropped. A victim query walks the tree and returns the way to refill. The walk never uses a tree bit as it is stored. Each decision bit is first replaced by an effective bit that the lock pattern of the set forces. As a result, a locked way is never returned while at least one way of the set is still unlocked. The stored bits themselves change on every update, locked or not.

The state sits in two synchronous-read arrays, one for the trees and one for the locks. Each array is updated by read-modify-write with a one-entry forwarding register, so commands to the same set may arrive on consecutive cycles. After reset, a sweep clears every set. The block accepts commands only once `ready` is high. A query result appears two clock edges after the query is sampled. It reflects every command accepted in earlier cycles and none accepted in the same cycle.

Top module: `plru_lock_victim`

## Requirements
- R1: After reset, `ready` stays low for SETS cycles while every set is cleared, and it then stays high. Commands and queries presented while `ready` is low have no effect and produce no result. Once `ready` is high, every set has all tree bits 0 and no locks, so a query returns way 0 with `vic_all_locked` low.
- R2: A query sampled at clock edge k drives `vic_vld` high, with its way and flag, in the cycle after edge k+1. The result includes every command sampled at an edge before k and excludes any command sampled at edge k.
- R3: An access to way w = {w2,w1,w0} writes three tree bits and leaves the other four unchanged. Bit 0 becomes ~w2. Bit 1 (when w2=0) or bit 2 (when w2=1) becomes ~w1. Leaf bit 3+{w2,w1} becomes ~w0.
- R4: The walk reads effective bits. With L the per-way lock vector:
  - E0 = &L[3:0] | (P0 & ~&L[7:4]).
  - E1 = (L0&L1) | (P1 & ~(L2&L3)).
  - E2 = (L4&L5) | (P2 & ~(L6&L7)).
  - E(3+k) = L(2k) | (P(3+k) & ~L(2k+1)), for k = 0..3.
  - The victim is {h,q,f}, where h=E0, q is E2 when h=1 and E1 otherwise, and f=E(3+{h,q}).
- R5: An invalidate of way w writes the complement of the R3 values on w's path. If w is unlocked, the next query on that set returns w.
- R6: A lock write selects a set and a way, chooses the instruction lock (`lk_instr`=1) or the data lock (`lk_instr`=0), and sets it (`lk_on`=1) or clears it (`lk_on`=0). A way counts as locked when either of its two locks is set. A locked way is never returned while the set has an unlocked way.
- R7: Access and invalidate update the tree whether or not the way is locked. Once the lock is removed, the effect of that earlier update is visible.
- R8: When all eight ways of the queried set are locked, `vic_all_locked` is 1 and `vic_way` is 0.
- R9: When an access and an invalidate are presented in the same cycle, the access is applied and the invalidate has no effect.
- R10: Commands change only the set they name. This includes set 0 and set SETS-1.
- R11: Tree and lock commands to the same set on consecutive cycles all take effect, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Clear sweep finished; commands accepted |
| acc_vld | input | 1 | Access (hit) command valid |
| acc_set | input | SET_W | Set of the access |
| acc_way | input | 3 | Way that was accessed |
| inv_vld | input | 1 | Invalidate command valid |
| inv_set | input | SET_W | Set of the invalidate |
| inv_way | input | 3 | Way that was invalidated |
| lk_vld | input | 1 | Lock write valid |
| lk_set | input | SET_W | Set of the lock write |
| lk_way | input | 3 | Way of the lock write |
| lk_instr | input | 1 | 1: instruction lock, 0: data lock |
| lk_on | input | 1 | 1: set the lock, 0: clear it |
| qry_vld | input | 1 | Victim query valid |
| qry_set | input | SET_W | Set to query |
| vic_vld | output | 1 | Query result valid |
| vic_way | output | 3 | Way to replace |
| vic_all_locked | output | 1 | Every way of the queried set is locked |

## Verification
The assertions check several properties on every cycle:
- Every access leaves the unmasked tree pointing away from the touched way, and every invalidate leaves it pointing at the dropped way.
- A returned victim is never a way that was locked in the state the query read.
- The all-locked flag coincides with a full lock vector and way 0.
- Results follow queries with fixed latency, and nothing emerges before `ready`.

Only the bench scenarios can show the rest:
- The exact tree contents that accumulate over long mixed sequences.
- The effect of updates made while a way was locked, seen after the lock is released.
- The precedence of access over invalidate.
- The forwarding of back-to-back commands to one set.
- The independence of sets.

// File: rtl/plru_lock_pkg.sv
package plru_lock_pkg;
  localparam int WAYS   = 8;
  localparam int WAY_W  = 3;
  localparam int TREE_W = WAYS - 1;

  typedef logic [TREE_W-1:0] tree_t;
  typedef logic [WAYS-1:0]   wmask_t;
  typedef logic [WAY_W-1:0]  way_t;

  typedef struct packed {
    wmask_t instr;
    wmask_t data;
  } lock_word_t;

  // Write the three bits on the path of way w; to_lru flips every value.
  function automatic tree_t tree_mark(tree_t cur, way_t w, logic to_lru);
    tree_t n;
    n = cur;
    n[0] = ~w[2] ^ to_lru;
    if (w[2]) n[2] = ~w[1] ^ to_lru;
    else      n[1] = ~w[1] ^ to_lru;
    n[3 + int'(w[2:1])] = ~w[0] ^ to_lru;
    return n;
  endfunction

  // Follow decision bits from the root to a leaf.
  function automatic way_t tree_walk(tree_t e);
    logic h, q, f;
    h = e[0];
    q = h ? e[2] : e[1];
    f = e[3 + int'({h, q})];
    return {h, q, f};
  endfunction
endpackage

// File: rtl/plru_rmw_bank.sv
module plru_rmw_bank #(
  parameter int W    = 7,
  parameter int SETS = 1024,
  localparam int AW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rda_addr,
  output logic [W-1:0]  rda_data,
  input  logic [AW-1:0] rdb_addr,
  output logic [W-1:0]  rdb_data
);
  logic [W-1:0]  mem [SETS];
  logic [W-1:0]  rda_q, rdb_q;
  logic [AW-1:0] rda_aq, rdb_aq;
  logic          fw_vld;
  logic [AW-1:0] fw_addr;
  logic [W-1:0]  fw_data;

  // Plain synchronous RAM: one write, two registered reads.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rda_q  <= mem[rda_addr];
    rdb_q  <= mem[rdb_addr];
    rda_aq <= rda_addr;
    rdb_aq <= rdb_addr;
  end

  // Last write, kept one cycle to cover the read-during-write gap.
  always_ff @(posedge clk) begin
    if (rst) fw_vld <= 1'b0;
    else     fw_vld <= wr_en;
    fw_addr <= wr_addr;
    fw_data <= wr_data;
  end

  assign rda_data = (fw_vld && fw_addr == rda_aq) ? fw_data : rda_q;
  assign rdb_data = (fw_vld && fw_addr == rdb_aq) ? fw_data : rdb_q;
endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_lock_pkg::*;
(
  input  tree_t cur,
  input  way_t  way,
  input  logic  to_lru,
  output tree_t nxt
);
  assign nxt = tree_mark(cur, way, to_lru);
endmodule

// File: rtl/plru_lock_mask.sv
module plru_lock_mask
  import plru_lock_pkg::*;
(
  input  tree_t      tree,
  input  lock_word_t locks,
  output way_t       way,
  output logic       all_locked
);
  wmask_t l;
  tree_t  e;

  assign l = locks.instr | locks.data;

  // Upper levels: a fully locked half forces the decision the other way.
  assign e[0] = (&l[3:0]) | (tree[0] & ~(&l[7:4]));
  assign e[1] = (l[0] & l[1]) | (tree[1] & ~(l[2] & l[3]));
  assign e[2] = (l[4] & l[5]) | (tree[2] & ~(l[6] & l[7]));

  // Leaves: a locked even way forces odd, a locked odd way forces even.
  for (genvar k = 0; k < WAYS / 2; k++) begin : g_leaf
    assign e[3+k] = l[2*k] | (tree[3+k] & ~l[2*k+1]);
  end

  assign all_locked = &l;
  assign way        = all_locked ? '0 : tree_walk(e);
endmodule

// File: rtl/plru_lock_victim.sv
module plru_lock_victim
  import plru_lock_pkg::*;
#(
  parameter int SETS  = 1024,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ready,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic [2:0]       acc_way,
  input  logic             inv_vld,
  input  logic [SET_W-1:0] inv_set,
  input  logic [2:0]       inv_way,
  input  logic             lk_vld,
  input  logic [SET_W-1:0] lk_set,
  input  logic [2:0]       lk_way,
  input  logic             lk_instr,
  input  logic             lk_on,
  input  logic             qry_vld,
  input  logic [SET_W-1:0] qry_set,
  output logic             vic_vld,
  output logic [2:0]       vic_way,
  output logic             vic_all_locked
);
  localparam int LOCK_W = $bits(lock_word_t);

  // ---------------- clear sweep ----------------
  logic             init_busy;
  logic [SET_W-1:0] init_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_cnt  <= '0;
    end else if (init_busy) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == SET_W'(SETS - 1)) init_busy <= 1'b0;
    end
  end

  assign ready = ~init_busy;

  // ---------------- command accept ----------------
  logic             acc_go, inv_go, lk_go, q_go;
  logic [SET_W-1:0] t_rd_set;
  way_t             t_rd_way;

  assign acc_go   = ready & acc_vld;
  assign inv_go   = ready & inv_vld & ~acc_vld;
  assign lk_go    = ready & lk_vld;
  assign q_go     = ready & qry_vld;
  assign t_rd_set = acc_vld ? acc_set : inv_set;
  assign t_rd_way = acc_vld ? acc_way : inv_way;

  // ---------------- stage 1 registers ----------------
  logic             t_vld, t_inv;
  way_t             t_way;
  logic [SET_W-1:0] t_set;
  logic             l_vld, l_instr, l_on;
  way_t             l_way;
  logic [SET_W-1:0] l_set;
  logic             q_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_vld <= 1'b0;
      l_vld <= 1'b0;
      q_vld <= 1'b0;
    end else begin
      t_vld <= acc_go | inv_go;
      l_vld <= lk_go;
      q_vld <= q_go;
    end
    t_inv   <= ~acc_vld;
    t_way   <= t_rd_way;
    t_set   <= t_rd_set;
    l_instr <= lk_instr;
    l_on    <= lk_on;
    l_way   <= lk_way;
    l_set   <= lk_set;
  end

  // ---------------- tree array ----------------
  tree_t            tree_rd, tree_q, tree_nxt, tree_wd;
  logic             tree_we;
  logic [SET_W-1:0] tree_wa;

  plru_tree_update u_upd (
    .cur    (tree_rd),
    .way    (t_way),
    .to_lru (t_inv),
    .nxt    (tree_nxt)
  );

  assign tree_we = init_busy | t_vld;
  assign tree_wa = init_busy ? init_cnt : t_set;
  assign tree_wd = init_busy ? '0 : tree_nxt;

  plru_rmw_bank #(.W(TREE_W), .SETS(SETS)) u_tree_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tree_we),
    .wr_addr  (tree_wa),
    .wr_data  (tree_wd),
    .rda_addr (t_rd_set),
    .rda_data (tree_rd),
    .rdb_addr (qry_set),
    .rdb_data (tree_q)
  );

  // ---------------- lock array ----------------
  lock_word_t       lock_rd, lock_q, lock_nxt, lock_wd;
  logic             lock_we;
  logic [SET_W-1:0] lock_wa;

  always_comb begin
    lock_nxt = lock_rd;
    if (l_instr) lock_nxt.instr[l_way] = l_on;
    else         lock_nxt.data[l_way]  = l_on;
  end

  assign lock_we = init_busy | l_vld;
  assign lock_wa = init_busy ? init_cnt : l_set;
  assign lock_wd = init_busy ? '0 : lock_nxt;

  plru_rmw_bank #(.W(LOCK_W), .SETS(SETS)) u_lock_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (lock_we),
    .wr_addr  (lock_wa),
    .wr_data  (lock_wd),
    .rda_addr (lk_set),
    .rda_data (lock_rd),
    .rdb_addr (qry_set),
    .rdb_data (lock_q)
  );

  // ---------------- victim ----------------
  way_t q_way;
  logic q_all;

  plru_lock_mask u_mask (
    .tree       (tree_q),
    .locks      (lock_q),
    .way        (q_way),
    .all_locked (q_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_vld        <= 1'b0;
      vic_way        <= '0;
      vic_all_locked <= 1'b0;
    end else begin
      vic_vld <= q_vld;
      if (q_vld) begin
        vic_way        <= q_way;
        vic_all_locked <= q_all;
      end
    end
  end

  // ---------------- assertions ----------------
  wmask_t q_lmask;
  assign q_lmask = lock_q.instr | lock_q.data;

  p_ready_hold_r1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_quiet_init_r1: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !vic_vld);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    q_vld |=> vic_vld);

  p_touch_away_r3: assert property (@(posedge clk) disable iff (rst)
    (t_vld && !t_inv) |-> (tree_walk(tree_nxt) != t_way));

  p_point_at_r5: assert property (@(posedge clk) disable iff (rst)
    (t_vld && t_inv) |-> (tree_walk(tree_nxt) == t_way));

  p_never_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (vic_vld && !vic_all_locked) |-> ((($past(q_lmask) >> vic_way) & 8'h01) == 8'h00));

  p_full_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (vic_vld && vic_all_locked) |-> (vic_way == 3'd0 && $past(q_lmask) == 8'hFF));
endmodule

// File: tb/plru_lock_victim_bench.sv
module plru_lock_victim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 1024;
  localparam int SW = $clog2(SETS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready;
  logic acc_vld = 0, inv_vld = 0, lk_vld = 0, qry_vld = 0;
  logic [SW-1:0] acc_set = '0, inv_set = '0, lk_set = '0, qry_set = '0;
  logic [2:0] acc_way = '0, inv_way = '0, lk_way = '0;
  logic lk_instr = 0, lk_on = 0;
  logic vic_vld, vic_all_locked;
  logic [2:0] vic_way;

  int total = 0;
  int bad = 0;

  logic [6:0] m_tree [SETS];
  logic [7:0] m_ilk [SETS];
  logic [7:0] m_dlk [SETS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  plru_lock_victim #(.SETS(SETS)) u_plru_lock_victim (
    .clk(clk), .rst(rst), .ready(ready),
    .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
    .inv_vld(inv_vld), .inv_set(inv_set), .inv_way(inv_way),
    .lk_vld(lk_vld), .lk_set(lk_set), .lk_way(lk_way), .lk_instr(lk_instr), .lk_on(lk_on),
    .qry_vld(qry_vld), .qry_set(qry_set),
    .vic_vld(vic_vld), .vic_way(vic_way), .vic_all_locked(vic_all_locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Reference update from R3/R5.
  function automatic logic [6:0] m_mark(logic [6:0] p, int w, bit inv);
    logic [6:0] n = p;
    int hi = (w >> 2) & 1;
    int mid = (w >> 1) & 1;
    int lo = w & 1;
    n[0] = inv ? hi[0] : !hi[0];
    n[hi ? 2 : 1] = inv ? mid[0] : !mid[0];
    n[3 + hi * 2 + mid] = inv ? lo[0] : !lo[0];
    return n;
  endfunction

  // Reference pick from R4/R8; returns 8 when every way is locked.
  function automatic int m_pick(logic [6:0] p, logic [7:0] lk);
    logic [6:0] e;
    int h, q, node;
    if (lk == 8'hFF) return 8;
    e[0] = (lk[0] && lk[1] && lk[2] && lk[3]) || (p[0] && !(lk[4] && lk[5] && lk[6] && lk[7]));
    e[1] = (lk[0] && lk[1]) || (p[1] && !(lk[2] && lk[3]));
    e[2] = (lk[4] && lk[5]) || (p[2] && !(lk[6] && lk[7]));
    for (int k = 0; k < 4; k++) e[3+k] = lk[2*k] || (p[3+k] && !lk[2*k+1]);
    h = e[0] ? 1 : 0;
    node = h ? 2 : 1;
    q = e[node] ? 1 : 0;
    return h * 4 + q * 2 + (e[3 + h * 2 + q] ? 1 : 0);
  endfunction

  function automatic int m_exp(int s);
    return m_pick(m_tree[s], m_ilk[s] | m_dlk[s]);
  endfunction

  task automatic idle();
    acc_vld = 0; inv_vld = 0; lk_vld = 0; qry_vld = 0;
  endtask

  task automatic put_acc(int s, int w);
    acc_vld = 1; acc_set = SW'(s); acc_way = 3'(w);
    m_tree[s] = m_mark(m_tree[s], w, 1'b0);
  endtask

  task automatic put_inv(int s, int w);
    inv_vld = 1; inv_set = SW'(s); inv_way = 3'(w);
    m_tree[s] = m_mark(m_tree[s], w, 1'b1);
  endtask

  task automatic put_lock(int s, int w, bit ins, bit on);
    lk_vld = 1; lk_set = SW'(s); lk_way = 3'(w); lk_instr = ins; lk_on = on;
    if (ins) m_ilk[s][w] = on;
    else     m_dlk[s][w] = on;
  endtask

  task automatic one(input int kind, input int s, input int w, input bit ins, input bit on);
    @(negedge clk);
    case (kind)
      0: put_acc(s, w);
      1: put_inv(s, w);
      default: put_lock(s, w, ins, on);
    endcase
    @(negedge clk);
    idle();
  endtask

  // Issue a query now, sample two edges later (R2).
  task automatic query(input int s, output int way, output bit al, output bit vv);
    @(negedge clk);
    qry_vld = 1; qry_set = SW'(s);
    @(negedge clk);
    qry_vld = 0;
    @(negedge clk);
    way = int'(vic_way); al = vic_all_locked; vv = vic_vld;
  endtask

  task automatic check_model(input int s, input string tag);
    int w, e; bit al, vv;
    e = m_exp(s);
    query(s, w, al, vv);
    chk(vv == 1'b1, {tag, " vic_vld"}, int'(vv), 1);
    chk(al == (e == 8), {tag, " all_locked"}, int'(al), int'(e == 8));
    chk(w == (e == 8 ? 0 : e), {tag, " way"}, w, (e == 8 ? 0 : e));
  endtask

  task automatic t_reset();
    int w; bit al, vv;
    chk(ready == 1'b0, "R1 ready low in init", int'(ready), 0);
    put_acc(7, 0);            // ignored: not yet ready
    m_tree[7] = '0;
    qry_vld = 1; qry_set = 7;
    repeat (3) @(negedge clk);
    chk(vic_vld == 1'b0, "R1 no result before ready", int'(vic_vld), 0);
    idle();
    while (!ready) @(negedge clk);
    query(0, w, al, vv);
    chk(vv && !al && w == 0, "R1 set 0 after clear", w, 0);
    query(SETS - 1, w, al, vv);
    chk(vv && !al && w == 0, "R1 last set after clear", w, 0);
    query(7, w, al, vv);
    chk(w == 0, "R1 access during init ignored", w, 0);
  endtask

  task automatic t_walk();
    int w; bit al, vv;
    for (int i = 0; i < 8; i++) one(0, 3, i, 0, 0);
    query(3, w, al, vv);
    chk(w == m_exp(3), "R3 R4 after ordered sweep", w, m_exp(3));
    for (int i = 0; i < 60; i++) begin
      one(0, 5 + (i % 3), int'($urandom_range(7)), 0, 0);
      if (i % 6 == 5) check_model(5 + (i % 3), "R3 R4 random access");
    end
  endtask

  task automatic t_inval();
    int w; bit al, vv;
    for (int i = 0; i < 8; i++) one(0, 10, 7 - i, 0, 0);
    one(1, 10, 5, 0, 0);
    query(10, w, al, vv);
    chk(w == 5, "R5 invalidated way next", w, 5);
    one(1, 10, 2, 0, 0);
    query(10, w, al, vv);
    chk(w == 2, "R5 second invalidate", w, 2);
  endtask

  task automatic t_locks();
    int w; bit al, vv;
    one(2, 12, 0, 1, 1);        // instr lock way 0
    one(2, 12, 0, 0, 1);        // data lock way 0
    one(2, 12, 0, 1, 0);        // clear instr, data still holds
    query(12, w, al, vv);
    chk(w != 0, "R6 data lock alone still masks", w, 1);
    one(2, 12, 0, 0, 0);
    query(12, w, al, vv);
    chk(w == 0, "R6 both cleared frees way", w, 0);
    for (int i = 0; i < 80; i++) begin
      int s = 14 + (i % 4);
      int k = int'($urandom_range(3));
      if (k == 3) one(1, s, int'($urandom_range(7)), 0, 0);
      else if (k == 2) one(2, s, int'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      else one(0, s, int'($urandom_range(7)), 0, 0);
      if (i % 5 == 4) check_model(s, "R6 random lock mix");
    end
  endtask

  task automatic t_locked_update();
    int w; bit al, vv;
    one(2, 20, 2, 0, 1);
    one(1, 20, 2, 0, 0);        // tree now points at locked way 2
    query(20, w, al, vv);
    chk(w != 2, "R7 locked way skipped", w, m_exp(20));
    one(2, 20, 2, 0, 0);
    query(20, w, al, vv);
    chk(w == 2, "R7 update kept while locked", w, 2);
  endtask

  task automatic t_all_locked();
    int w; bit al, vv;
    for (int i = 0; i < 8; i++) one(2, 25, i, (i % 2) == 1, 1);
    one(0, 25, 4, 0, 0);
    query(25, w, al, vv);
    chk(al == 1'b1, "R8 flag set", int'(al), 1);
    chk(w == 0, "R8 way forced 0", w, 0);
    one(2, 25, 6, 0, 0);        // way 6 was data-locked
    query(25, w, al, vv);
    chk(al == 1'b0 && w == 6, "R8 single free way", w, 6);
  endtask

  task automatic t_same_cycle();
    int w;
    @(negedge clk);
    qry_vld = 1; qry_set = 30;
    put_acc(30, 0);
    inv_vld = 1; inv_set = 30; inv_way = 3;   // not applied to model: R9
    @(negedge clk);
    idle();
    @(negedge clk);
    w = int'(vic_way);
    chk(vic_vld && w == 0, "R2 same-cycle query sees old state", w, 0);
    query(30, w, w[0], w[1]);
    check_model(30, "R9 access wins over invalidate");
    chk(m_exp(30) == 4, "R9 reference after access only", m_exp(30), 4);
  endtask

  task automatic t_back_to_back();
    int w; bit al, vv;
    @(negedge clk); put_acc(40, 1);
    @(negedge clk); idle(); put_acc(40, 6);
    @(negedge clk); idle(); put_inv(40, 3);
    @(negedge clk); idle(); put_lock(40, 3, 1, 1);
    @(negedge clk); idle(); put_lock(40, 3, 0, 1);
    @(negedge clk); idle(); put_lock(40, 3, 1, 0);
    @(negedge clk); idle(); put_acc(40, 0);
    @(negedge clk); idle();
    qry_vld = 1; qry_set = 40;   // query right after the last command
    @(negedge clk); idle();
    @(negedge clk);
    w = int'(vic_way);
    chk(vic_vld && w == m_exp(40), "R11 consecutive same-set updates", w, m_exp(40));
    chk(w != 3, "R11 data lock from chain holds", w, m_exp(40));
    one(2, 40, 3, 0, 0);
    query(40, w, al, vv);
    chk(w == m_exp(40), "R11 after unlock", w, m_exp(40));
  endtask

  task automatic t_sets();
    int w; bit al, vv;
    one(0, 50, 0, 0, 0);
    one(2, 50, 1, 1, 1);
    query(51, w, al, vv);
    chk(w == 0 && !al, "R10 neighbour set untouched", w, 0);
    one(0, SETS - 1, 0, 0, 0);
    query(SETS - 1, w, al, vv);
    chk(w == 4, "R10 last set updated", w, 4);
    query(0, w, al, vv);
    chk(w == 0, "R10 set 0 untouched", w, 0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_tree[s] = '0; m_ilk[s] = '0; m_dlk[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_walk();
    t_inval();
    t_locks();
    t_locked_update();
    t_all_locked();
    t_same_cycle();
    t_back_to_back();
    t_sets();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule